// File: doc/BRIEF.md
# Underflow Interrupt Decimation Counter

This block sits next to a periodic down-counting timer and turns its stream of underflow pulses into a sparser interrupt request. Software writes a divide value n (1 to 15). An interrupt pulse then appears on every nth counted underflow. A mode input selects what is counted: either every underflow, or only those underflows that arrive while a qualifier input is high.

An early-first option shortens the first period after a start to n-1 counted underflows. Every period after that is a full n. A write port loads n. Writes are screened: a write that could corrupt a running count is dropped, and a sticky error flag records it. Software clears the flag.

The interrupt output is a single-clock pulse. It is registered on the clock edge that samples the terminal underflow.

Top module: `udec_irq_top`

## Requirements
- R1: After reset, irq and err are 0 and the divide value is 1. With no write, every counted underflow therefore produces an interrupt.
- R2: With mode_sel=0 and run=1, each underflow is counted. irq is high for exactly the one cycle after the edge that samples the nth counted underflow, and the count then restarts. If n is lowered below the current count, the next counted underflow fires.
- R3: With mode_sel=1, an underflow is counted only when qual=1 in the same cycle. Underflows with qual=0 change nothing.
- R4: With early_sel=1 and n>1, the first interrupt after a start follows n-1 counted underflows. Every later interrupt follows n.
- R5: With early_sel=1 and n=1, the first interrupt follows the first counted underflow.
- R6: While run=0, underflows are not counted and irq stays 0.
- R7: A write with a nonzero value while run=0 is accepted, clears the count, and sets the divide value used from the next start.
- R8: A write while run=1 and mode_sel=1 is ignored (n unchanged) and sets err.
- R9: A write while run=1 in the same cycle as unf=1 is ignored and sets err.
- R10: A write of value 0 is ignored and sets err.
- R11: err stays set until a cycle with err_clr=1 and no new error. A new error in the same cycle as err_clr wins.
- R12: A rising edge of run clears the count and restarts the first period. An underflow in that same cycle is the first counted one.
- R13: A write while run=1, mode_sel=0 and unf=0 is accepted. It takes effect on the following count decision without clearing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the divide value |
| wr_data | input | 4 | Divide value n, legal 1..15 |
| mode_sel | input | 1 | 0: count every underflow, 1: count only qualified underflows |
| early_sel | input | 1 | 1: first period after start is n-1 |
| run | input | 1 | Timer running enable |
| unf | input | 1 | Timer underflow pulse |
| qual | input | 1 | Qualifier used when mode_sel=1 |
| err_clr | input | 1 | Clears the sticky error flag |
| irq | output | 1 | One-cycle interrupt request pulse |
| err | output | 1 | Sticky rejected-write flag |

## Verification
A wrong count value shows as an irq pulse that is early or late relative to the counted underflows. This shows up no later than the next terminal underflow, which is at most 15 counted events later. A lost first-period flag moves only the first pulse after a start, so the bench restarts the timer often with early_sel high. A wrongly accepted write changes the spacing of pulses from the next period onward. It also leaves err low on the following cycle, which the bench checks at once.

// File: rtl/udec_pkg.sv
// Shared constants for the underflow decimation counter.
// Assumes the divide field is narrow (a few bits); the count never exceeds it.
package udec_pkg;
    localparam int unsigned DEC_W     = 4;
    localparam int unsigned DEC_RESET = 1;
endpackage

// File: rtl/udec_ctrl_reg.sv
// Divide-value register with write screening and a sticky error flag.
// Does: accepts a nonzero write when it cannot disturb a running count.
// Assumes: unf is only meaningful while run is high.
module udec_ctrl_reg #(
    parameter int unsigned W       = udec_pkg::DEC_W,
    parameter int unsigned N_RESET = udec_pkg::DEC_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         run,
    input  logic         unf,
    input  logic         mode_sel,
    input  logic         err_clr,
    output logic [W-1:0] n_q,
    output logic         wr_ok,
    output logic         err_q
);
    logic reject;

    // Classify the write: zero value, qualified mode while running, or underflow clash.
    always_comb begin
        reject = wr_en && ((wr_data == '0) || (run && (unf || mode_sel)));
        wr_ok  = wr_en && !reject;
    end

    // Hold the divide value; only accepted writes change it.
    always_ff @(posedge clk) begin
        if (!rst_n)     n_q <= W'(N_RESET);
        else if (wr_ok) n_q <= wr_data;
    end

    // Sticky error: set on a rejected write, set takes priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (reject)  err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end
endmodule

// File: rtl/udec_qualify.sv
// Event qualification: decides which underflows are counted and detects start.
// Assumes run is a level from synchronous logic.
module udec_qualify (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic unf,
    input  logic qual,
    input  logic mode_sel,
    output logic cnt_ev,
    output logic start
);
    logic run_q;

    // Remember last cycle's run level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    // Counted event and start pulse.
    always_comb begin
        start  = run && !run_q;
        cnt_ev = run && unf && (!mode_sel || qual);
    end
endmodule

// File: rtl/udec_counter.sv
// Decimation counter: counts events and emits a one-cycle request on the terminal one.
// Assumes n_cur is nonzero; start and clear never coincide (clear only while stopped).
module udec_counter #(
    parameter int unsigned W = udec_pkg::DEC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_ev,
    input  logic         start,
    input  logic         clear,
    input  logic         early_sel,
    input  logic [W-1:0] n_cur,
    output logic         irq
);
    logic [W-1:0] cnt_q;
    logic         first_q;
    logic [W-1:0] base;
    logic         first_eff;
    logic [W-1:0] target;
    logic [W:0]   next_cnt;
    logic         fire;

    // Work out the terminal count for the current period.
    always_comb begin
        base      = start ? '0 : cnt_q;
        first_eff = start || first_q;
        if (first_eff && early_sel && (n_cur > W'(1))) target = n_cur - W'(1);
        else                                           target = n_cur;
        next_cnt  = {1'b0, base} + (W+1)'(1);
        fire      = cnt_ev && (next_cnt >= {1'b0, target});
    end

    // Advance or wrap the count, and track the first period after a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else if (clear) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else if (fire) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else if (cnt_ev) begin
            cnt_q   <= next_cnt[W-1:0];
            first_q <= first_eff;
        end else begin
            cnt_q   <= base;
            first_q <= first_eff;
        end
    end

    // Register the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire;
    end
endmodule

// File: rtl/udec_irq_top.sv
// Top of the underflow interrupt decimation counter.
// Wires the control register, event qualifier and counter together.
// Assumes all inputs are synchronous to clk.
module udec_irq_top #(
    parameter int unsigned W = udec_pkg::DEC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         mode_sel,
    input  logic         early_sel,
    input  logic         run,
    input  logic         unf,
    input  logic         qual,
    input  logic         err_clr,
    output logic         irq,
    output logic         err
);
    logic [W-1:0] n_cur;
    logic         wr_ok;
    logic         cnt_ev;
    logic         start;
    logic         clr_cnt;

    // An accepted write while stopped restarts the count.
    always_comb clr_cnt = wr_ok && !run;

    udec_ctrl_reg #(.W(W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .run(run), .unf(unf), .mode_sel(mode_sel), .err_clr(err_clr),
        .n_q(n_cur), .wr_ok(wr_ok), .err_q(err)
    );

    udec_qualify qual_i (
        .clk(clk), .rst_n(rst_n), .run(run), .unf(unf), .qual(qual),
        .mode_sel(mode_sel), .cnt_ev(cnt_ev), .start(start)
    );

    udec_counter #(.W(W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .cnt_ev(cnt_ev), .start(start),
        .clear(clr_cnt), .early_sel(early_sel), .n_cur(n_cur), .irq(irq)
    );
endmodule

// File: rtl/udec_irq_chk.sv
// Property checker for udec_irq_top, attached by bind.
module udec_irq_chk #(
    parameter int unsigned W = udec_pkg::DEC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         mode_sel,
    input logic         run,
    input logic         unf,
    input logic         qual,
    input logic         err_clr,
    input logic         irq,
    input logic         err,
    input logic [W-1:0] n_cur
);
    p_irq_needs_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(run && unf));

    p_qual_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq && $past(mode_sel) |-> $past(qual));

    p_run_mode_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && run && mode_sel |=> err && $stable(n_cur));

    p_clash_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && run && unf |=> err && $stable(n_cur));

    p_zero_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_data == '0) |=> err && $stable(n_cur));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err && !err_clr |=> err);

    p_n_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        n_cur != '0);
endmodule

bind udec_irq_top udec_irq_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode_sel(mode_sel), .run(run), .unf(unf), .qual(qual),
    .err_clr(err_clr), .irq(irq), .err(err), .n_cur(n_cur)
);

// File: tb/udec_irq_top_tb_top.sv
module udec_irq_top_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         mode_sel = 1'b0;
    logic         early_sel = 1'b0;
    logic         run = 1'b0;
    logic         unf = 1'b0;
    logic         qual = 1'b0;
    logic         err_clr = 1'b0;
    logic         irq;
    logic         err;

    int errors = 0;
    int checks = 0;

    // Reference state derived from the requirements.
    int m_n, m_cnt;
    bit m_first, m_run_q, m_err, m_irq;

    always #5 clk = ~clk;

    udec_irq_top #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode_sel(mode_sel), .early_sel(early_sel), .run(run), .unf(unf),
        .qual(qual), .err_clr(err_clr), .irq(irq), .err(err)
    );

    task automatic model_reset();
        m_n = 1; m_cnt = 0; m_first = 1; m_run_q = 0; m_err = 0; m_irq = 0;
    endtask

    function automatic int target_of(int n, bit f, bit e);
        return (f && e && n > 1) ? n - 1 : n;
    endfunction

    // Advance the reference by one clock using the current inputs.
    task automatic model_step();
        bit st, rej, acc, ev, f;
        int base;
        st   = run && !m_run_q;
        rej  = wr_en && (wr_data == 0 || (run && (unf || mode_sel)));
        acc  = wr_en && !rej;
        ev   = run && unf && (!mode_sel || qual);
        base = st ? 0 : m_cnt;
        f    = st || m_first;
        m_irq = 0;
        if (acc && !run) begin
            m_cnt = 0; m_first = 1;
        end else if (ev && base + 1 >= target_of(m_n, f, early_sel)) begin
            m_irq = 1; m_cnt = 0; m_first = 0;
        end else begin
            m_cnt = ev ? base + 1 : base; m_first = f;
        end
        if (rej) m_err = 1;
        else if (err_clr) m_err = 0;
        if (acc) m_n = int'(wr_data);
        m_run_q = run;
    endtask

    task automatic check(string tag);
        checks++;
        if (irq !== m_irq || err !== m_err) begin
            errors++;
            $display("FAIL %s: irq=%b err=%b expected irq=%b err=%b at %0t",
                     tag, irq, err, m_irq, m_err, $time);
        end
    endtask

    // One cycle: drive at negedge, update model, sample after the edge.
    task automatic step(bit w, int d, bit m, bit e, bit r, bit u, bit q, bit c, string tag);
        @(negedge clk);
        wr_en = w; wr_data = W'(d); mode_sel = m; early_sel = e;
        run = r; unf = u; qual = q; err_clr = c;
        model_step();
        @(posedge clk);
        #1;
        check(tag);
    endtask

    // Watchdog.
    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1; check("R1 reset");

        // R1: default n=1, every underflow fires.
        for (int i = 0; i < 4; i++) step(0,0,0,0,1,1,0,0,"R1");
        step(0,0,0,0,0,0,0,0,"R6");

        // R7: write n=3 while stopped, then R2 counting with gaps.
        step(1,3,0,0,0,0,0,0,"R7");
        for (int i = 0; i < 9; i++) step(0,0,0,0,1,(i%2==0),0,0,"R2");
        // R6: stopped, underflows ignored.
        for (int i = 0; i < 5; i++) step(0,0,0,0,0,1,0,0,"R6");

        // R4: early first with n=4.
        step(1,4,0,1,0,0,0,0,"R7");
        for (int i = 0; i < 12; i++) step(0,0,0,1,1,1,0,0,"R4");
        step(0,0,0,1,0,0,0,0,"R12");
        // R12: restart clears and reopens first period.
        for (int i = 0; i < 5; i++) step(0,0,0,1,1,1,0,0,"R12");

        // R5: early with n=1.
        step(0,0,0,1,0,0,0,0,"R5");
        step(1,1,0,1,0,0,0,0,"R5");
        for (int i = 0; i < 3; i++) step(0,0,0,1,1,1,0,0,"R5");

        // R3: qualified mode.
        step(0,0,1,0,0,0,0,0,"R3");
        step(1,2,1,0,0,0,0,0,"R3");
        for (int i = 0; i < 8; i++) step(0,0,1,0,1,1,(i%3==0),0,"R3");

        // R8: write while running in qualified mode.
        step(1,5,1,0,1,0,0,0,"R8");
        step(0,0,1,0,1,0,0,1,"R11");
        // R9: write clashing with underflow in mode 0.
        step(1,7,0,0,1,1,0,0,"R9");
        step(0,0,0,0,1,0,0,0,"R11");
        // R11: set wins over clear.
        step(1,0,0,0,1,0,0,1,"R11");
        step(0,0,0,0,1,0,0,1,"R11");
        // R10: zero write while stopped.
        step(1,0,0,0,0,0,0,0,"R10");
        step(0,0,0,0,0,0,0,1,"R10");
        // R13: running write in mode 0, lowering n mid-count.
        step(1,9,0,0,0,0,0,0,"R13");
        for (int i = 0; i < 5; i++) step(0,0,0,0,1,1,0,0,"R13");
        step(1,2,0,0,1,0,0,0,"R13");
        for (int i = 0; i < 5; i++) step(0,0,0,0,1,1,0,0,"R2");

        // Constrained random phase.
        for (int i = 0; i < 3000; i++) begin
            bit w, m, e, r, u, q, c;
            int d;
            string tag;
            w = ($urandom_range(0, 15) == 0);
            d = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 15);
            m = (i / 500) % 2 == 1;
            e = (i / 250) % 2 == 1;
            r = ($urandom_range(0, 19) != 0);
            u = ($urandom_range(0, 2) != 0);
            q = $urandom_range(0, 1) == 1;
            c = ($urandom_range(0, 7) == 0);
            tag = w ? "R9" : (m ? "R3" : (e ? "R4" : "R2"));
            step(w, d, m, e, r, u, q, c, tag);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule